// File: doc/BRIEF.md
# Serial receive holding register with status flags

This block sits between a serial deserializer and software. Each time the deserializer finishes a frame it raises a completion strobe and presents the assembled byte, with a separate strobe that marks a frame as bad. A byte from a clean frame is copied into a holding register and a "buffer full" flag goes high. If another clean frame finishes before software has emptied the buffer, an "overrun" flag goes high instead. The old byte is kept and the new one is thrown away.

Software reaches the block through a small register port with two addresses. One address returns the held byte. The other returns the two flags. A flag can only be lowered by a two-step handshake: software first reads the status while the flag is high, then writes a zero to that flag's bit. While an overrun is pending the block accepts no further frames. In clock-synchronous operation it also raises a signal that holds off the transmitter. Reset and standby entry drop both flags. Both flags are also presented as level outputs for interrupt logic.

Top module: `rxbuf_stat`

## Requirements
- R1: A completion strobe with the error strobe low, with receive enable high, with the full flag at 0 and with no overrun pending, copies the input byte into the holding register and sets the full flag on that clock edge.
- R2: Reset, or standby being high at a clock edge, clears the full flag, the overrun flag and both read-armed bits. Standby does not alter the held byte.
- R3: The full flag is cleared by a status-address write whose bit 1 is 0. That write must follow a status read that returned bit 1 as 1. Each such read permits exactly one clearing write.
- R4: A clean accepted frame that arrives while the full flag is 1 sets the overrun flag and leaves the held byte unchanged.
- R5: The overrun flag is cleared by a status-address write whose bit 0 is 0. That write must follow a status read that returned bit 0 as 1.
- R6: None of the following changes the flags: writing 1 to a flag bit, writing 0 without an armed read, or writing to the data address. A write to the data address also leaves the held byte unchanged.
- R7: A frame completing with the error strobe high changes neither the held byte, the full flag nor the overrun flag.
- R8: While receive enable is low, completion strobes are ignored, and the held byte and both flags keep their values.
- R9: While the overrun flag is 1, completion strobes are ignored, even if the full flag has been cleared.
- R10: The transmit-inhibit output is 1 exactly when the overrun flag is 1 and the synchronous-mode input is 1.
- R11: When a clearing write and a clean frame fall in the same cycle, the clear is applied first. The frame is then evaluated against the cleared flags: with full cleared it loads, full stays 1 and no overrun is raised.
- R12: The read data follows the address combinationally. Address 0 returns the full flag in bit 1 and the overrun flag in bit 0, with zeros elsewhere. Address 1 returns the held byte. Reading address 1 does not arm any clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Standby request; clears flags while high |
| rx_en | input | 1 | Receive enable |
| sync_mode | input | 1 | High in clock-synchronous operation |
| fr_done | input | 1 | Frame-complete strobe from the deserializer |
| fr_err | input | 1 | Frame error strobe |
| fr_data | input | DATA_W | Assembled byte |
| reg_sel | input | ADDR_W | Register address (0 status, 1 data) |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data |
| full_o | output | 1 | Buffer-full flag level |
| ovr_o | output | 1 | Overrun flag level |
| tx_inhibit | output | 1 | Transmit hold-off in synchronous mode |

## Verification
The hardest case to reach is a clearing write that lands in the same cycle as a clean frame. The bench arms the full flag with a status read. On one falling edge it then drives the zero-write together with a completion strobe, and checks that the new byte replaced the old one with no overrun. A second hard case is a pending overrun with the full flag already lowered. To reach it, the bench clears only the full bit with a write that keeps bit 0 at 1, and then shows that a further frame is dropped. The bench also checks that standby disarms a pending read, by attempting the zero-write after standby.

// File: rtl/rxbs_pkg.sv
package rxbs_pkg;
   localparam int FLAG_FULL = 0;
   localparam int FLAG_OVR  = 1;
   localparam int NFLAGS    = 2;

   typedef struct packed {
      logic ovr;
      logic full;
   } rxbs_flags_t;
endpackage

// File: rtl/rxbs_arm.sv
module rxbs_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic standby,
   input  logic flag,
   input  logic rd_hit,
   input  logic wr_hit,
   input  logic wbit,
   output logic clr
);
   logic arm_q;

   assign clr = wr_hit & ~wbit & arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         arm_q <= 1'b0;
      else if (standby)
         arm_q <= 1'b0;
      else if (clr)
         arm_q <= 1'b0;
      else if (rd_hit && flag)
         arm_q <= 1'b1;
   end
endmodule

// File: rtl/rxbs_capture.sv
module rxbs_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby,
   input  logic              accept,
   input  logic [DATA_W-1:0] fr_data,
   input  logic              clr_full,
   input  logic              clr_ovr,
   output logic              full_q,
   output logic              ovr_q,
   output logic [DATA_W-1:0] data_q
);
   logic f_mid, o_mid, take, load, full_n, ovr_n;

   always_comb begin
      f_mid  = full_q & ~clr_full;
      o_mid  = ovr_q & ~clr_ovr;
      take   = accept & ~o_mid;
      load   = take & ~f_mid;
      full_n = f_mid | take;
      ovr_n  = o_mid | (take & f_mid);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
         data_q <= '0;
      end else if (standby) begin
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         full_q <= full_n;
         ovr_q  <= ovr_n;
         if (load)
            data_q <= fr_data;
      end
   end
endmodule

// File: rtl/rxbuf_stat.sv
module rxbuf_stat
   import rxbs_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int ADDR_W       = 1,
   parameter int STAT_ADDR    = 0,
   parameter int DATA_ADDR    = 1,
   parameter int FULL_POS     = 1,
   parameter int OVR_POS      = 0,
   parameter bit SYNC_TX_GATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby,
   input  logic              rx_en,
   input  logic              sync_mode,
   input  logic              fr_done,
   input  logic              fr_err,
   input  logic [DATA_W-1:0] fr_data,
   input  logic [ADDR_W-1:0] reg_sel,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              full_o,
   output logic              ovr_o,
   output logic              tx_inhibit
);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must hold both flag bits");
   end
   if (FULL_POS == OVR_POS || FULL_POS >= DATA_W || OVR_POS >= DATA_W) begin : g_bad_pos
      $error("flag bit positions must be distinct and inside DATA_W");
   end
   if (STAT_ADDR == DATA_ADDR || STAT_ADDR >= (1 << ADDR_W) || DATA_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register addresses must be distinct and fit ADDR_W");
   end

   logic              stat_rd, stat_wr, accept;
   logic [NFLAGS-1:0] flag_vec, wbit_vec, clr_vec;
   logic [DATA_W-1:0] rx_data_q;
   rxbs_flags_t       flags;

   assign stat_rd = reg_rd & (reg_sel == STAT_A);
   assign stat_wr = reg_wr & (reg_sel == STAT_A);
   assign accept  = fr_done & rx_en & ~fr_err;

   assign flags.full = full_o;
   assign flags.ovr  = ovr_o;

   assign flag_vec[FLAG_FULL] = flags.full;
   assign flag_vec[FLAG_OVR]  = flags.ovr;
   assign wbit_vec[FLAG_FULL] = reg_wdata[FULL_POS];
   assign wbit_vec[FLAG_OVR]  = reg_wdata[OVR_POS];

   for (genvar g = 0; g < NFLAGS; g++) begin : g_arm
      rxbs_arm u_arm (
         .clk    (clk),
         .rst_n  (rst_n),
         .standby(standby),
         .flag   (flag_vec[g]),
         .rd_hit (stat_rd),
         .wr_hit (stat_wr),
         .wbit   (wbit_vec[g]),
         .clr    (clr_vec[g])
      );
   end

   rxbs_capture #(.DATA_W(DATA_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .standby (standby),
      .accept  (accept),
      .fr_data (fr_data),
      .clr_full(clr_vec[FLAG_FULL]),
      .clr_ovr (clr_vec[FLAG_OVR]),
      .full_q  (full_o),
      .ovr_q   (ovr_o),
      .data_q  (rx_data_q)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_sel == STAT_A) begin
         reg_rdata[FULL_POS] = flags.full;
         reg_rdata[OVR_POS]  = flags.ovr;
      end else if (reg_sel == DATA_A) begin
         reg_rdata = rx_data_q;
      end
   end

   if (SYNC_TX_GATE) begin : g_tx_gate
      assign tx_inhibit = flags.ovr & sync_mode;
   end else begin : g_no_tx_gate
      assign tx_inhibit = 1'b0;
   end
endmodule

// File: rtl/rxbs_chk.sv
module rxbs_chk #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 1,
   parameter int STAT_ADDR = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              standby,
   input logic              rx_en,
   input logic              sync_mode,
   input logic              fr_done,
   input logic              fr_err,
   input logic [DATA_W-1:0] fr_data,
   input logic [ADDR_W-1:0] reg_sel,
   input logic              reg_wr,
   input logic              full_o,
   input logic              ovr_o,
   input logic              tx_inhibit,
   input logic [DATA_W-1:0] data_q
);
   logic stat_wr;
   assign stat_wr = reg_wr && (reg_sel == ADDR_W'(STAT_ADDR));

   p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_done && rx_en && !fr_err && !full_o && !ovr_o && !standby)
      |=> (full_o && data_q == $past(fr_data)));

   p_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> (!full_o && !ovr_o && $stable(data_q)));

   p_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(full_o) |-> $past(standby || stat_wr));

   p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_done && rx_en && !fr_err && full_o && !ovr_o && !standby && !stat_wr)
      |=> (ovr_o && $stable(data_q)));

   p_ovr_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovr_o) |-> $past(standby || stat_wr));

   p_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_err && !standby && !stat_wr)
      |=> ($stable(data_q) && $stable(full_o) && $stable(ovr_o)));

   p_rxen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !standby && !stat_wr)
      |=> ($stable(data_q) && $stable(full_o) && $stable(ovr_o)));

   p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_o && !standby && !stat_wr) |=> ($stable(data_q) && ovr_o));

   p_txinh_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_mode || !ovr_o) |-> !tx_inhibit);
endmodule

bind rxbuf_stat rxbs_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .STAT_ADDR(STAT_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .standby   (standby),
   .rx_en     (rx_en),
   .sync_mode (sync_mode),
   .fr_done   (fr_done),
   .fr_err    (fr_err),
   .fr_data   (fr_data),
   .reg_sel   (reg_sel),
   .reg_wr    (reg_wr),
   .full_o    (full_o),
   .ovr_o     (ovr_o),
   .tx_inhibit(tx_inhibit),
   .data_q    (rx_data_q)
);

// File: tb/rxbuf_stat_test.sv
`timescale 1ns/1ps
module rxbuf_stat_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       standby = 1'b0, rx_en = 1'b1, sync_mode = 1'b0;
   logic       fr_done = 1'b0, fr_err = 1'b0;
   logic [7:0] fr_data = '0;
   logic [0:0] reg_sel = '0;
   logic       reg_rd = 1'b0, reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       full_o, ovr_o, tx_inhibit;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   rxbuf_stat uut (
      .clk(clk), .rst_n(rst_n), .standby(standby), .rx_en(rx_en),
      .sync_mode(sync_mode), .fr_done(fr_done), .fr_err(fr_err),
      .fr_data(fr_data), .reg_sel(reg_sel), .reg_rd(reg_rd),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .full_o(full_o), .ovr_o(ovr_o), .tx_inhibit(tx_inhibit)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic frame(input logic [7:0] d, input logic err);
      @(negedge clk);
      fr_done = 1'b1; fr_err = err; fr_data = d;
      @(negedge clk);
      fr_done = 1'b0; fr_err = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] v);
      @(negedge clk);
      reg_sel = a; reg_rd = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wr(input logic a, input logic [7:0] v);
      @(negedge clk);
      reg_sel = a; reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic stat(input string tag, input logic f, input logic o);
      logic [7:0] v;
      rd(1'b0, v);
      chk({tag, " status"}, v, {6'b0, f, o});
   endtask

   task automatic data(input string tag, input logic [7:0] e);
      logic [7:0] v;
      rd(1'b1, v);
      chk({tag, " data"}, v, e);
   endtask

   task automatic t_reset;
      chk("R2 reset full", full_o, 0);
      chk("R2 reset ovr", ovr_o, 0);
      chk("R10 reset txinh", tx_inhibit, 0);
   endtask

   task automatic t_load;
      frame(8'hA5, 1'b0);
      chk("R1 full", full_o, 1);
      data("R12 R1", 8'hA5);
      chk("R12 data read no arm", full_o, 1);
   endtask

   task automatic t_clear;
      logic [7:0] v;
      wr(1'b0, 8'h00);
      chk("R6 zero without read", full_o, 1);
      wr(1'b1, 8'h00);
      chk("R6 data addr write flag", full_o, 1);
      data("R6 data addr write", 8'hA5);
      rd(1'b0, v);
      chk("R12 status map", v, 8'h02);
      wr(1'b0, 8'hFF);
      chk("R6 write one", full_o, 1);
      wr(1'b0, 8'h00);
      chk("R3 armed clear", full_o, 0);
      frame(8'h5A, 1'b0);
      wr(1'b0, 8'h00);
      chk("R3 one clear per read", full_o, 1);
      stat("R3 pre", 1'b1, 1'b0);
      wr(1'b0, 8'h00);
   endtask

   task automatic t_overrun;
      frame(8'h11, 1'b0);
      frame(8'h22, 1'b0);
      chk("R4 ovr set", ovr_o, 1);
      data("R4 old kept", 8'h11);
      chk("R10 async txinh", tx_inhibit, 0);
      sync_mode = 1'b1;
      #1 chk("R10 sync txinh", tx_inhibit, 1);
      stat("R4", 1'b1, 1'b1);
      wr(1'b0, 8'h01);
      chk("R3 full cleared", full_o, 0);
      chk("R5 ovr kept by one", ovr_o, 1);
      frame(8'h33, 1'b0);
      chk("R9 stalled full", full_o, 0);
      data("R9 stalled", 8'h11);
      wr(1'b0, 8'h00);
      chk("R5 ovr cleared", ovr_o, 0);
      chk("R10 txinh drops", tx_inhibit, 0);
      sync_mode = 1'b0;
      frame(8'h44, 1'b0);
      data("R5 resumed", 8'h44);
   endtask

   task automatic t_err;
      frame(8'h55, 1'b1);
      chk("R7 err no ovr", ovr_o, 0);
      data("R7 err full case", 8'h44);
      stat("R7", 1'b1, 1'b0);
      wr(1'b0, 8'h00);
      frame(8'h56, 1'b1);
      chk("R7 err no full", full_o, 0);
      data("R7 err empty case", 8'h44);
   endtask

   task automatic t_rxen;
      rx_en = 1'b0;
      frame(8'h66, 1'b0);
      chk("R8 no full", full_o, 0);
      data("R8", 8'h44);
      rx_en = 1'b1;
   endtask

   task automatic t_same;
      frame(8'h77, 1'b0);
      stat("R11 arm", 1'b1, 1'b0);
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 8'h00;
      fr_done = 1'b1; fr_data = 8'h88;
      @(negedge clk);
      reg_wr = 1'b0; fr_done = 1'b0;
      chk("R11 full", full_o, 1);
      chk("R11 no ovr", ovr_o, 0);
      data("R11", 8'h88);
   endtask

   task automatic t_standby;
      frame(8'h99, 1'b0);
      chk("R2 pre ovr", ovr_o, 1);
      @(negedge clk); standby = 1'b1;
      @(negedge clk); standby = 1'b0;
      chk("R2 sb full", full_o, 0);
      chk("R2 sb ovr", ovr_o, 0);
      data("R2 sb keeps", 8'h88);
      frame(8'hC3, 1'b0);
      stat("R2 arm", 1'b1, 1'b0);
      @(negedge clk); standby = 1'b1;
      @(negedge clk); standby = 1'b0;
      frame(8'h3C, 1'b0);
      wr(1'b0, 8'h00);
      chk("R2 arm cleared", full_o, 1);
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_load();
      t_clear();
      t_overrun();
      t_err();
      t_rxen();
      t_same();
      t_standby();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule